// File: doc/BRIEF.md
# Bus Request/Grant Controller

This block sits between a processor core's external memory port and a shared external bus. Another master that wants the bus raises a request. The controller passes that request through a synchronizer and, at the first cycle in which no external access is on the bus, hands the bus over. Handing over means three things happen together: it raises grant, turns off this processor's address, data, select and strobe drivers, and halts the core. When the request drops, grant falls, the drivers come back on and the core carries on from where it stopped.

An access already in flight is never cut short. The handover waits for the access to finish, however many wait states it takes. It does not wait for the rest of the instruction, so the bus can change hands between the two accesses of one instruction. In go mode the core keeps running while the bus is away and is halted only when it needs the bus. Whenever the core has an external access waiting because the bus is held elsewhere, a hang flag tells the other masters to let go.

Top module: `bus_grant_ctrl`

## Requirements
- R1: With no access on the bus, a request that goes high before rising edge E1 makes grant high after rising edge E3 (two synchronizer flops and one output register). `drv_en_o` is always the inverse of `bus_grant_o`.
- R2: If an access is in progress (`acc_busy_i` high, with `acc_done_i` high in its last cycle of L cycles, starting in the same cycle the request is first sampled), grant rises after edge max(3, L). Grant never rises in a cycle where the access is busy and not done.
- R3: If `acc_two_i` is high in the done cycle of the first access of an instruction and the request is active, grant is still issued after that edge. The second access is then recorded as pending.
- R4: With go mode off, `core_halt_o` rises on the same edge as grant.
- R5: With go mode on, `core_halt_o` stays low while the bus is granted. It rises one edge after the core raises `acc_want_i`.
- R6: After the request goes low, grant falls, `drv_en_o` rises and `core_halt_o` falls, all on the third rising edge.
- R7: An access wanted while the bus is granted is held as pending. `grant_hang_o` goes high one edge after the pending state is set.
- R8: The pending state survives release of the bus, and no new grant is issued while it is set. It clears on the first edge that sees `acc_busy_i` with grant low, and `grant_hang_o` falls one edge later.
- R9: While `rst` is high, grant still follows the synchronized request with the R1 latency, even if `acc_busy_i` is high. During reset, `core_halt_o` and `grant_hang_o` are held low and the pending state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the core-side state |
| bus_req_i | input | 1 | Asynchronous bus request from another master |
| go_mode_i | input | 1 | Keep executing while the bus is granted away |
| acc_want_i | input | 1 | Core needs an external access |
| acc_busy_i | input | 1 | External access occupies the bus this cycle |
| acc_done_i | input | 1 | Last cycle of the current external access |
| acc_two_i | input | 1 | Current instruction needs a second access right after this one |
| bus_grant_o | output | 1 | Bus granted to the other master |
| drv_en_o | output | 1 | Enable for address, data, select and strobe drivers |
| core_halt_o | output | 1 | Stop the core |
| grant_hang_o | output | 1 | Core is stalled waiting for the bus |

## Verification
Grant latency is measured with the bus idle and against accesses of 1 to 8 cycles, both fixed and random lengths. These runs separate the synchronizer-bound latency of three edges from the access-bound latency of L edges. The go-mode run and the run with go mode off show whether halt is tied to grant or to the core's first access demand. The two-access run and the re-request-while-pending run show whether the pending access is kept and given priority. A run with reset held shows that the handshake ignores an in-flight access during reset.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  // core-side view of the external access port
  typedef struct packed {
    logic want;
    logic busy;
    logic done;
    logic two;
  } core_acc_t;

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  // no reset: the request path must keep working while rst is high
  always_ff @(posedge clk) begin
    chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/bgc_grant_path.sv
module bgc_grant_path
  import bgc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_s,
  input  core_acc_t acc,
  input  logic      pend_q,
  output logic      grant_d,
  output logic      grant_q,
  output logic      drv_en_q
);
  // the bus is free when nothing is on it or the access ends this cycle
  logic bus_free;
  assign bus_free = !acc.busy || acc.done;

  always_comb begin
    if (rst)          grant_d = req_s;            // access aborted by reset
    else if (grant_q) grant_d = req_s;            // hold until release
    else              grant_d = req_s && !pend_q && bus_free;
  end

  always_ff @(posedge clk) begin
    grant_q  <= grant_d;
    drv_en_q <= !grant_d;
  end

  // R2: never hand over in the middle of an access
  p_defer_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!grant_q && acc.busy && !acc.done) |=> !grant_q);

  // R6: release follows the synchronized request
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (grant_q && !req_s) |=> (!grant_q && drv_en_q));

  // R8: a waiting access wins over a new request
  p_pend_block_r8: assert property (@(posedge clk) disable iff (rst)
    (!grant_q && pend_q) |=> !grant_q);
endmodule

// File: rtl/bgc_stall_track.sv
module bgc_stall_track
  import bgc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go_mode,
  input  core_acc_t acc,
  input  logic      grant_d,
  input  logic      grant_q,
  output logic      pend_q,
  output logic      halt_q,
  output logic      hang_q
);
  logic pend_d;
  logic halt_d;

  always_comb begin
    if (pend_q)
      pend_d = !(acc.busy && !grant_q);           // clears once the access starts
    else
      pend_d = (grant_q && acc.want) ||
               (!grant_q && grant_d && acc.done && acc.two);
  end

  assign halt_d = grant_d && (!go_mode || pend_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      halt_q <= 1'b0;
      hang_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      halt_q <= halt_d;
      hang_q <= pend_q;
    end
  end

  // R7: pending only ever arises with the bus away
  p_pend_origin_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> grant_q);

  // R4: without go mode halt comes with grant
  p_halt_nogo_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(grant_q) && !$past(go_mode) && !$past(rst)) |-> halt_q);

  // R5: in go mode halt while granted only for a waiting access
  p_halt_go_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(halt_q) && $past(go_mode) && $past(grant_q)) |-> pend_q);
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
  import bgc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_i,
  input  logic go_mode_i,
  input  logic acc_want_i,
  input  logic acc_busy_i,
  input  logic acc_done_i,
  input  logic acc_two_i,
  output logic bus_grant_o,
  output logic drv_en_o,
  output logic core_halt_o,
  output logic grant_hang_o
);
  core_acc_t acc;
  logic      req_s;
  logic      grant_d;
  logic      grant_q;
  logic      drv_en_q;
  logic      pend_q;
  logic      halt_q;
  logic      hang_q;

  assign acc = '{want: acc_want_i, busy: acc_busy_i,
                 done: acc_done_i, two: acc_two_i};

  bgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (bus_req_i),
    .q   (req_s)
  );

  bgc_grant_path u_grant (
    .clk      (clk),
    .rst      (rst),
    .req_s    (req_s),
    .acc      (acc),
    .pend_q   (pend_q),
    .grant_d  (grant_d),
    .grant_q  (grant_q),
    .drv_en_q (drv_en_q)
  );

  bgc_stall_track u_stall (
    .clk     (clk),
    .rst     (rst),
    .go_mode (go_mode_i),
    .acc     (acc),
    .grant_d (grant_d),
    .grant_q (grant_q),
    .pend_q  (pend_q),
    .halt_q  (halt_q),
    .hang_q  (hang_q)
  );

  assign bus_grant_o  = grant_q;
  assign drv_en_o     = drv_en_q;
  assign core_halt_o  = halt_q;
  assign grant_hang_o = hang_q;
endmodule

// File: tb/test_bus_grant_ctrl.sv
`timescale 1ns/1ps
module test_bus_grant_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, go = 1'b0, want = 1'b0, busy = 1'b0, done = 1'b0, two = 1'b0;
  logic grant, drv_en, halt, hang;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_grant_ctrl i_bus_grant_ctrl (
    .clk(clk), .rst(rst), .bus_req_i(req), .go_mode_i(go),
    .acc_want_i(want), .acc_busy_i(busy), .acc_done_i(done), .acc_two_i(two),
    .bus_grant_o(grant), .drv_en_o(drv_en), .core_halt_o(halt), .grant_hang_o(hang)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    tick(4);
    chk(grant, 1'b0, "R9 reset grant");
    chk(drv_en, 1'b1, "R1 reset drv_en");
    chk(halt, 1'b0, "R9 reset halt");
    chk(hang, 1'b0, "R9 reset hang");
  endtask

  task automatic t_reset_grant;
    busy = 1'b1; req = 1'b1;
    tick(2); chk(grant, 1'b0, "R9 grant early in reset");
    tick(1); chk(grant, 1'b1, "R9 grant in reset despite busy");
    chk(drv_en, 1'b0, "R1 drv_en off in reset");
    chk(halt, 1'b0, "R9 halt low in reset");
    req = 1'b0;
    tick(3); chk(grant, 1'b0, "R9 release in reset");
    chk(drv_en, 1'b1, "R6 drv_en back in reset");
    busy = 1'b0; rst = 1'b0;
    tick(2);
  endtask

  task automatic t_idle_grant;
    go = 1'b0; req = 1'b1;
    tick(2); chk(grant, 1'b0, "R1 grant before third edge");
    tick(1); chk(grant, 1'b1, "R1 grant on third edge");
    chk(drv_en, 1'b0, "R1 drv_en off with grant");
    chk(halt, 1'b1, "R4 halt with grant");
    req = 1'b0;
    tick(2); chk(grant, 1'b1, "R6 grant held two edges");
    tick(1); chk(grant, 1'b0, "R6 grant falls");
    chk(drv_en, 1'b1, "R6 drv_en restored");
    chk(halt, 1'b0, "R6 halt released");
    tick(2);
  endtask

  task automatic t_deferred(input int len);
    int exp_edge;
    exp_edge = (len > 3) ? len : 3;
    go = 1'b0; req = 1'b1; busy = 1'b1; done = (len == 1);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      busy = (k + 1 <= len);
      done = (k + 1 == len);
      chk(grant, (k >= exp_edge), $sformatf("R2 len=%0d edge=%0d grant", len, k));
    end
    req = 1'b0; busy = 1'b0; done = 1'b0;
    tick(3); chk(grant, 1'b0, $sformatf("R6 len=%0d release", len));
    tick(2);
  endtask

  task automatic t_mid_instr;
    go = 1'b0; req = 1'b1; busy = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      busy = (k + 1 <= 4);
      done = (k + 1 == 4);
      two  = (k + 1 == 4);
      if (k == 3) chk(grant, 1'b0, "R3 no grant before first access ends");
      if (k == 4) begin
        chk(grant, 1'b1, "R3 grant between accesses");
        chk(halt, 1'b1, "R4 halt mid instruction");
        chk(hang, 1'b0, "R7 hang not yet");
      end
      if (k == 5) chk(hang, 1'b1, "R3 second access pending hang");
    end
    req = 1'b0;
    tick(3);
    chk(grant, 1'b0, "R6 mid release grant");
    chk(halt, 1'b0, "R6 mid release halt");
    chk(hang, 1'b1, "R8 hang kept after release");
    busy = 1'b1; done = 1'b1;
    tick(1); chk(hang, 1'b1, "R8 hang one edge after start");
    busy = 1'b0; done = 1'b0;
    tick(1); chk(hang, 1'b0, "R8 hang cleared");
    tick(2);
  endtask

  task automatic t_go_mode;
    go = 1'b1; req = 1'b1;
    tick(3);
    chk(grant, 1'b1, "R5 go grant");
    chk(halt, 1'b0, "R5 go no halt at grant");
    tick(3); chk(halt, 1'b0, "R5 go keeps running");
    want = 1'b1;
    tick(1);
    chk(halt, 1'b1, "R5 halt on access demand");
    chk(hang, 1'b0, "R7 hang lags pending");
    tick(1); chk(hang, 1'b1, "R7 hang raised");
    req = 1'b0;
    tick(3);
    chk(grant, 1'b0, "R6 go release grant");
    chk(halt, 1'b0, "R6 go release halt");
    chk(hang, 1'b1, "R8 go hang held");
    req = 1'b1;
    tick(6); chk(grant, 1'b0, "R8 no regrant while pending");
    req = 1'b0;
    tick(3);
    want = 1'b0; busy = 1'b1; done = 1'b1;
    tick(1);
    busy = 1'b0; done = 1'b0;
    chk(hang, 1'b1, "R8 go hang one edge after start");
    tick(1); chk(hang, 1'b0, "R8 go hang cleared");
    go = 1'b0;
    tick(2);
  endtask

  initial begin
    t_reset_state();
    t_reset_grant();
    t_idle_grant();
    t_deferred(1);
    t_deferred(2);
    t_deferred(3);
    t_deferred(4);
    t_deferred(8);
    for (int i = 0; i < 4; i++) t_deferred(int'($urandom_range(8, 1)));
    t_mid_instr();
    t_go_mode();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule